// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Device Model

This block is a synthesizable pin-level stand-in for a 16-bit-wide static RAM. It is used where a board-level memory must be replaced in a simulation or emulation build. It accepts the memory's raw control pins: a low-true and a high-true chip enable, a low-true write strobe, a low-true output enable and one low-true enable for each byte lane. From these pins it works out the device mode: standby, output disabled, read or write. Each byte lane is handled on its own.

The bidirectional data bus is split into three parts: a data-in vector, a data-out vector and one drive-enable bit per byte lane. Reads are combinational from the current pins and the stored contents. Writes are taken in on a sampling clock. A byte lane's write window is open while the chip is selected, the write strobe is low and that lane's enable is low. The address and data of the last sampled cycle of the window are stored at the sampling edge where the window is first seen closed. The depth is a parameter, and addresses wrap at that depth.

All pins are plain level signals with no valid/ready handshake. The model applies no back-pressure. The driving logic owns the timing, as it would with a real asynchronous part.

Top module: `bsram_model`

## Requirements
- R1: Unless `ce_n` is 0 and `ce` is 1, both lanes are released (`dq_oe` = 2'b00), `active` is 0 and no byte is written.
- R2: When `lb_n` and `ub_n` are both 1, the model is in standby whatever the other pins are: `active` is 0, `dq_oe` is 2'b00 and nothing is written.
- R3: In read mode (selected, `we_n` = 1, `oe_n` = 0), lane 0 (bits 7:0, enabled by `lb_n`) and lane 1 (bits 15:8, enabled by `ub_n`) each drive the stored byte at the addressed word only when their own enable is 0. `dq_oe[0]` belongs to lane 0 and `dq_oe[1]` to lane 1.
- R4: When selected with `we_n` = 1 and `oe_n` = 1, `dq_oe` is 2'b00 and `active` is 1.
- R5: Whenever `we_n` is 0, `dq_oe` is 2'b00. When the model is also selected, `active` is 1.
- R6: A write stores only the lanes whose enable is 0. The other byte of the word keeps its earlier value.
- R7: A lane's write window closes when any of its conditions goes inactive. The stored byte and address are those sampled on the last clock edge of the window, even if the data changed earlier within the window.
- R8: Only the low log2(DEPTH) address bits select a word, so an address and that address plus DEPTH refer to the same word.
- R9: While `rst_n` is 0, any write window in progress is dropped and nothing is stored.
- R10: The byte of `dq_out` belonging to a lane that is not driving is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for write capture |
| rst_n | input | 1 | Asynchronous active-low reset of write capture state |
| ce_n | input | 1 | Chip enable, active low |
| ce | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lane 0 (bits 7:0) enable, active low |
| ub_n | input | 1 | Lane 1 (bits 15:8) enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data presented to the model for writes |
| dq_out | output | 16 | Data driven by the model, 0 on idle lanes |
| dq_oe | output | 2 | Per-lane drive enable, bit 0 = low lane |
| active | output | 1 | 1 in read, write or output-disabled mode; 0 in standby |

## Verification
The bench builds the model with DEPTH = 64 and the full 19-bit address. With this small depth, aliasing can be reached in a couple of writes (words 12 and 76, and words 63 and 127 overlap), and the top word of the array is exercised. A behavioural reference keeps the contents and one pending write per lane. It is compared with the mode, lane enables and data on every clock. Scripted sequences cover the cases that decide correctness: write windows closed by each kind of condition, data that changes inside a window, and a window cut off by reset.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_OUT_OFF = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } bsram_mode_e;
endpackage

// File: rtl/bsram_mode_dec.sv
module bsram_mode_dec
  import bsram_pkg::*;
(
  input  logic             ce_n,
  input  logic             ce,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] be_n,
  output bsram_mode_e      mode,
  output logic [LANES-1:0] lane_wr,
  output logic [LANES-1:0] lane_rd
);
  logic chip_on;
  logic any_lane;
  logic selected;

  assign chip_on  = ~ce_n & ce;
  assign any_lane = ~(&be_n);
  assign selected = chip_on & any_lane;

  always_comb begin
    if (!selected)      mode = MODE_STANDBY;
    else if (!we_n)     mode = MODE_WRITE;
    else if (!oe_n)     mode = MODE_READ;
    else                mode = MODE_OUT_OFF;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_wr[l] = (mode == MODE_WRITE) & ~be_n[l];
    assign lane_rd[l] = (mode == MODE_READ)  & ~be_n[l];
  end
endmodule

// File: rtl/bsram_lane_wr.sv
module bsram_lane_wr #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANE_W-1:0] data_i,
  output logic              commit_o,
  output logic [IDX_W-1:0]  commit_idx_o,
  output logic [LANE_W-1:0] commit_data_o
);
  logic              hold_act;
  logic [IDX_W-1:0]  hold_idx;
  logic [LANE_W-1:0] hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_act  <= 1'b0;
      hold_idx  <= '0;
      hold_data <= '0;
    end else if (wr_i) begin
      hold_act  <= 1'b1;
      hold_idx  <= idx_i;
      hold_data <= data_i;
    end else begin
      hold_act  <= 1'b0;
    end
  end

  assign commit_o      = hold_act & ~wr_i;
  assign commit_idx_o  = hold_idx;
  assign commit_data_o = hold_data;

  // R7: a commit follows directly on a window that was open at the last edge
  a_r7_commit_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(wr_i));
endmodule

// File: rtl/bsram_lane_store.sv
module bsram_lane_store #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LANE_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [LANE_W-1:0] rd_data_o
);
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/bsram_model.sv
module bsram_model
  import bsram_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              ce,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [1:0]        dq_oe,
  output logic              active
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  bsram_mode_e      mode;
  logic [LANES-1:0] be_n;
  logic [LANES-1:0] lane_wr;
  logic [LANES-1:0] lane_rd;
  logic [IDX_W-1:0] idx;

  assign be_n = {ub_n, lb_n};
  assign idx  = addr[IDX_W-1:0];

  bsram_mode_dec u_dec (
    .ce_n    (ce_n),
    .ce      (ce),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .be_n    (be_n),
    .mode    (mode),
    .lane_wr (lane_wr),
    .lane_rd (lane_rd)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic              commit;
    logic [IDX_W-1:0]  commit_idx;
    logic [LANE_W-1:0] commit_data;
    logic [LANE_W-1:0] rd_byte;

    bsram_lane_wr #(.IDX_W(IDX_W), .LANE_W(LANE_W)) u_wr (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_i          (lane_wr[l]),
      .idx_i         (idx),
      .data_i        (dq_in[l*LANE_W +: LANE_W]),
      .commit_o      (commit),
      .commit_idx_o  (commit_idx),
      .commit_data_o (commit_data)
    );

    bsram_lane_store #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_store (
      .clk       (clk),
      .we_i      (commit),
      .wr_idx_i  (commit_idx),
      .wr_data_i (commit_data),
      .rd_idx_i  (idx),
      .rd_data_o (rd_byte)
    );

    assign dq_out[l*LANE_W +: LANE_W] = lane_rd[l] ? rd_byte : '0;
    assign dq_oe[l] = lane_rd[l];
  end

  assign active = (mode != MODE_STANDBY);

  // R1: chip enables not both asserted -> bus released, standby
  a_r1_deselect_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || !ce) |-> (dq_oe == 2'b00 && !active));
  // R2: both lane enables high -> standby
  a_r2_no_lane_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_n && ub_n) |-> (dq_oe == 2'b00 && !active));
  // R3: a lane drives only in read mode with its own enable low
  a_r3_low_lane_owner: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[0] |-> (!lb_n && !oe_n && we_n && !ce_n && ce));
  a_r3_high_lane_owner: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[1] |-> (!ub_n && !oe_n && we_n && !ce_n && ce));
  // R5: write strobe low -> nothing driven
  a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe == 2'b00));
  // R10: idle lanes present zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!dq_oe[0] |-> dq_out[7:0] == 8'h00) and (!dq_oe[1] |-> dq_out[15:8] == 8'h00));
endmodule

// File: tb/tb_bsram_model.sv
`timescale 1ns/1ps
module tb_bsram_model;
  localparam int DEPTH  = 64;
  localparam int ADDR_W = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, ce = 1'b0, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic        active;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [7:0] m_byte [DEPTH][2];
  bit         m_valid[DEPTH][2];
  bit         h_act[2];
  int         h_idx[2];
  logic [7:0] h_dat[2];

  always #2.5 clk = ~clk;

  bsram_model #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce(ce), .we_n(we_n), .oe_n(oe_n),
    .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .active(active)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit sel_now();
    return (!ce_n && ce && !(lb_n && ub_n));
  endfunction

  task automatic model_edge();
    bit s;
    int idx;
    s = sel_now();
    idx = int'(addr) % DEPTH;
    for (int l = 0; l < 2; l++) begin
      bit en;
      en = (l == 0) ? !lb_n : !ub_n;
      if (!rst_n) h_act[l] = 0;
      else if (s && !we_n && en) begin
        h_act[l] = 1; h_idx[l] = idx; h_dat[l] = dq_in[l*8 +: 8];
      end else if (h_act[l]) begin
        m_byte[h_idx[l]][l] = h_dat[l];
        m_valid[h_idx[l]][l] = 1;
        h_act[l] = 0;
      end
    end
  endtask

  task automatic compare_all();
    string tag;
    bit s;
    logic [1:0] eoe;
    int idx;
    s = sel_now();
    idx = int'(addr) % DEPTH;
    if (ce_n || !ce)        tag = "R1";
    else if (lb_n && ub_n)  tag = "R2";
    else if (!we_n)         tag = "R5";
    else if (oe_n)          tag = "R4";
    else                    tag = "R3";
    eoe[0] = s && we_n && !oe_n && !lb_n;
    eoe[1] = s && we_n && !oe_n && !ub_n;
    chk(active == s, tag, "active", {15'd0, active}, {15'd0, s});
    chk(dq_oe == eoe, tag, "dq_oe", {14'd0, dq_oe}, {14'd0, eoe});
    for (int l = 0; l < 2; l++) begin
      if (!eoe[l])
        chk(dq_out[l*8 +: 8] == 8'h00, "R10", "idle lane", {8'd0, dq_out[l*8 +: 8]}, 16'h0000);
      else if (m_valid[idx][l])
        chk(dq_out[l*8 +: 8] == m_byte[idx][l], "R3", "lane data",
            {8'd0, dq_out[l*8 +: 8]}, {8'd0, m_byte[idx][l]});
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic pins(input logic cen, input logic cep, input logic wen, input logic oen,
                      input logic lbn, input logic ubn, input int a, input logic [15:0] d);
    ce_n = cen; ce = cep; we_n = wen; oe_n = oen; lb_n = lbn; ub_n = ubn;
    addr = ADDR_W'(a); dq_in = d;
  endtask

  task automatic idle();
    pins(1, 0, 1, 1, 1, 1, 0, 16'h0);
    tick();
  endtask

  task automatic write_word(input int a, input logic [15:0] d, input logic lbn, input logic ubn);
    pins(0, 1, 0, 1, lbn, ubn, a, d);
    tick();
    pins(0, 1, 1, 1, lbn, ubn, a, d);
    tick();
  endtask

  task automatic read_word(input int a, input logic lbn, input logic ubn,
                           input logic [15:0] exp, input string tag);
    pins(0, 1, 1, 0, lbn, ubn, a, 16'h0);
    tick();
    chk(dq_out == exp, tag, "read word", dq_out, exp);
  endtask

  initial begin
    // R9: reset state, deselected
    idle(); idle();
    chk(dq_oe == 2'b00 && !active && dq_out == 16'h0, "R9", "reset outputs",
        {13'd0, active, dq_oe}, 16'h0);
    rst_n = 1;
    idle();

    write_word(5, 16'h1234, 0, 0);
    read_word(5, 0, 0, 16'h1234, "R3");
    chk(dq_oe == 2'b11, "R3", "both lanes on", {14'd0, dq_oe}, 16'h0003);
    write_word(5, 16'h55AB, 0, 1);
    read_word(5, 0, 0, 16'h12AB, "R6");
    write_word(5, 16'hCD66, 1, 0);
    read_word(5, 0, 0, 16'hCDAB, "R6");
    read_word(5, 0, 1, 16'h00AB, "R3");
    chk(dq_oe == 2'b01, "R10", "low lane only", {14'd0, dq_oe}, 16'h0001);
    read_word(5, 1, 0, 16'hCD00, "R3");
    chk(dq_oe == 2'b10, "R10", "high lane only", {14'd0, dq_oe}, 16'h0002);

    // R4: output disabled
    pins(0, 1, 1, 1, 0, 0, 5, 16'h0); tick();
    chk(active && dq_oe == 2'b00, "R4", "out off", {14'd0, dq_oe}, 16'h0);

    // R5: write with oe_n low still releases bus
    pins(0, 1, 0, 0, 0, 0, 7, 16'h5555); tick();
    chk(active && dq_oe == 2'b00, "R5", "write quiet", {14'd0, dq_oe}, 16'h0);
    pins(0, 1, 1, 1, 0, 0, 7, 16'h5555); tick();
    read_word(7, 0, 0, 16'h5555, "R5");

    // R1: each chip enable alone blocks a write
    pins(0, 0, 0, 1, 0, 0, 5, 16'hFFFF); tick();
    chk(!active, "R1", "ce low", {15'd0, active}, 16'h0);
    pins(1, 1, 0, 1, 0, 0, 5, 16'hFFFF); tick();
    chk(!active, "R1", "ce_n high", {15'd0, active}, 16'h0);
    idle();
    read_word(5, 0, 0, 16'hCDAB, "R1");

    // R2: both lane enables high blocks a write
    pins(0, 1, 0, 1, 1, 1, 5, 16'hEEEE); tick();
    chk(!active, "R2", "no lanes", {15'd0, active}, 16'h0);
    idle();
    read_word(5, 0, 0, 16'hCDAB, "R2");

    // R7: data changing inside window, closed by ce_n
    pins(0, 1, 0, 1, 0, 0, 9, 16'h1111); tick();
    pins(0, 1, 0, 1, 0, 0, 9, 16'h2222); tick();
    pins(0, 1, 0, 1, 0, 0, 9, 16'h3333); tick();
    pins(1, 1, 0, 1, 0, 0, 9, 16'h4444); tick();
    read_word(9, 0, 0, 16'h3333, "R7");

    // R7: low lane window closed early by lb_n
    pins(0, 1, 0, 1, 0, 0, 10, 16'hAAAA); tick();
    pins(0, 1, 0, 1, 1, 0, 10, 16'hBBBB); tick();
    pins(0, 1, 1, 1, 1, 0, 10, 16'hBBBB); tick();
    read_word(10, 0, 0, 16'hBBAA, "R7");

    // R8: aliasing at DEPTH
    write_word(12 + DEPTH, 16'h7777, 0, 0);
    read_word(12, 0, 0, 16'h7777, "R8");
    write_word(DEPTH - 1, 16'h0F0F, 0, 0);
    read_word(2 * DEPTH - 1, 0, 0, 16'h0F0F, "R8");

    // R9: reset cuts an open window
    pins(0, 1, 0, 1, 0, 0, 5, 16'h9999); tick();
    rst_n = 0;
    pins(1, 0, 1, 1, 1, 1, 5, 16'h9999); tick();
    rst_n = 1;
    idle();
    read_word(5, 0, 0, 16'hCDAB, "R9");

    idle();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule